// File: doc/BRIEF.md
# Watchdog and Low-Voltage Reset Generator

This block supervises a host processor and pulls its reset line low on either of two events: a software watchdog that runs out because nobody restarted it in time, or a supply-voltage sense input reporting that the rail is below its trip point. It runs on a 32.768 kHz timekeeping clock. A two-bit select picks one of three watchdog periods (a quarter, three quarters or one and three quarters of a second, which are 1, 3 and 7 times a base count of 8192 cycles) or switches the watchdog off. The restart strobe is raised by activity on the serial bus.

A watchdog timeout produces a reset pulse of fixed length. After the pulse the watchdog counts again from zero, so a stuck host sees repeated pulses. A low-supply report holds reset for as long as the condition lasts and for a settling time after it clears. The same settling time applies after power-on. The output models an open-drain pin: 0 drives the line low, 1 releases it.

Top module: `wdr_supervisor`

## Requirements
- R1: While `por_n` is low, `host_rst_n` is 0. After `por_n` rises, `host_rst_n` stays 0 until the SETTLE_CYC-th rising clock edge and is 1 after it.
- R2: `wd_sel` encoding: 0 gives BASE_CYC cycles, 1 gives 3*BASE_CYC, 2 gives 7*BASE_CYC, and 3 is off. With no restart, `host_rst_n` falls exactly one period after the edge that last restarted the count.
- R3: A watchdog reset pulse holds `host_rst_n` at 0 for exactly PULSE_CYC cycles. A restart strobe during the pulse neither shortens nor extends it.
- R4: When a watchdog pulse ends, the count restarts from zero. With no restart, the next pulse starts one period after the end of the previous one.
- R5: A restart strobe `wd_kick` sampled high clears the count. Strobes spaced closer than one period prevent every watchdog reset.
- R6: With `wd_sel` = 3 the count is held cleared and no watchdog reset occurs, however long the setting stays.
- R7: A change of `wd_sel`, sampled at a clock edge, restarts the count from zero under the new period.
- R8: With `lv_en` = 1, `lv_below` sampled high pulls `host_rst_n` to 0 from that edge on. It stays 0 while the input stays high and is released at the SETTLE_CYC-th edge that samples `lv_below` low.
- R9: With `lv_en` = 0, `lv_below` has no effect on `host_rst_n`.
- R10: While a low-voltage reset is active the watchdog is held cleared. It restarts from zero at the edge that releases the low-voltage reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wd_sel | input | 2 | Watchdog period select (0 short, 1 middle, 2 long, 3 off) |
| wd_kick | input | 1 | Watchdog restart strobe, one cycle per serial-bus access |
| lv_below | input | 1 | Comparator result: 1 when the supply is below the trip threshold |
| lv_en | input | 1 | Enable for low-voltage sensing |
| host_rst_n | output | 1 | Reset to host, 0 = drive low, 1 = release (open drain) |

## Verification
The watchdog is run with each of the three period settings and left to expire. This separates the three period counts from one another and from the length of the pulse itself. Regular restarts, the off setting and a mid-count switch from the long to the short period show whether the count is cleared by the right events and only by them. Restarts during a pulse check that the pulse length stays the same. The low-voltage input is driven with sensing enabled and then disabled. It is also driven in the middle of a watchdog count, which shows that the two reset sources combine on the output and that the watchdog starts again from zero after a supply event.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

  typedef enum logic [1:0] {
    WD_SHORT = 2'd0,
    WD_MID   = 2'd1,
    WD_LONG  = 2'd2,
    WD_OFF   = 2'd3
  } wd_sel_e;

  // Timeout length in clock cycles for a select code; 0 when off.
  function automatic int unsigned wd_period_cycles(input logic [1:0] sel,
                                                   input int unsigned base);
    case (sel)
      WD_SHORT: return base;
      WD_MID:   return 3 * base;
      WD_LONG:  return 7 * base;
      default:  return 0;
    endcase
  endfunction

  // Counter width able to hold the longest timeout.
  function automatic int unsigned wd_count_width(input int unsigned base);
    return $clog2(7 * base + 1);
  endfunction

endpackage

// File: rtl/wdr_wdog_timer.sv
module wdr_wdog_timer #(
  parameter int unsigned BASE_CYC = 8192
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] sel,
  input  logic       kick,
  input  logic       hold,
  output logic       expire
);
  import wdr_pkg::*;

  localparam int unsigned CW = wd_count_width(BASE_CYC);

  logic [CW-1:0] cnt;
  logic [CW-1:0] period;
  logic [1:0]    sel_q;
  logic          sel_chg;
  logic          clear;

  assign period  = CW'(wd_period_cycles(sel, BASE_CYC));
  assign sel_chg = (sel != sel_q);
  assign clear   = kick | sel_chg | (sel == WD_OFF) | hold;
  assign expire  = !clear && (cnt == period - CW'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt   <= '0;
      sel_q <= WD_OFF;
    end else begin
      sel_q <= sel;
      if (clear || expire) cnt <= '0;
      else                 cnt <= cnt + CW'(1);
    end
  end

  // R5: a restart leaves the count at zero, so no timeout can follow at once
  assert_kick_no_expire_R5: assert property (@(posedge clk) disable iff (!por_n)
    kick |=> !expire);

endmodule

// File: rtl/wdr_pulse_gen.sv
module wdr_pulse_gen #(
  parameter int unsigned PULSE_CYC = 8192
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic active
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] left;

  assign active = (left != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              left <= '0;
    else if (fire)           left <= PW'(PULSE_CYC);
    else if (left != '0)     left <= left - PW'(1);
  end

endmodule

// File: rtl/wdr_lv_hold.sv
module wdr_lv_hold #(
  parameter int unsigned SETTLE_CYC = 4096
) (
  input  logic clk,
  input  logic por_n,
  input  logic lv_en,
  input  logic lv_below,
  output logic active
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] settle;
  logic          low_now;

  assign low_now = lv_en & lv_below;
  assign active  = (settle != '0);

  // Power-on loads the full settling time, so start-up behaves like a supply recovery.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             settle <= SW'(SETTLE_CYC);
    else if (low_now)       settle <= SW'(SETTLE_CYC);
    else if (settle != '0)  settle <= settle - SW'(1);
  end

endmodule

// File: rtl/wdr_supervisor.sv
module wdr_supervisor #(
  parameter int unsigned BASE_CYC   = 8192,
  parameter int unsigned PULSE_CYC  = 8192,
  parameter int unsigned SETTLE_CYC = 4096
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] wd_sel,
  input  logic       wd_kick,
  input  logic       lv_below,
  input  logic       lv_en,
  output logic       host_rst_n
);
  // Internal events brought out as named wires.
  logic wd_expire;
  logic wd_pulse;
  logic lv_rst;
  logic wd_hold;

  assign wd_hold = wd_pulse | lv_rst;

  wdr_wdog_timer #(.BASE_CYC(BASE_CYC)) u_timer (
    .clk    (clk),
    .por_n  (por_n),
    .sel    (wd_sel),
    .kick   (wd_kick),
    .hold   (wd_hold),
    .expire (wd_expire)
  );

  wdr_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk    (clk),
    .por_n  (por_n),
    .fire   (wd_expire),
    .active (wd_pulse)
  );

  wdr_lv_hold #(.SETTLE_CYC(SETTLE_CYC)) u_lv (
    .clk      (clk),
    .por_n    (por_n),
    .lv_en    (lv_en),
    .lv_below (lv_below),
    .active   (lv_rst)
  );

  assign host_rst_n = !(wd_pulse | lv_rst);

  // R3: a timeout is followed by the reset line being driven low
  assert_expire_pulls_low_R3: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |=> !host_rst_n);

  // R8: an enabled low-supply report pulls reset low on the next cycle
  assert_lv_pulls_low_R8: assert property (@(posedge clk) disable iff (!por_n)
    (lv_en && lv_below) |=> !host_rst_n);

  // R9: the low-voltage hold starts only from an enabled low-supply report
  assert_lv_needs_enable_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(lv_rst) |-> $past(lv_en && lv_below));

  // R10: the watchdog cannot time out while a low-voltage reset is held
  assert_no_expire_in_lv_R10: assert property (@(posedge clk) disable iff (!por_n)
    lv_rst |-> !wd_expire);

  // R4: no new timeout while a watchdog pulse is still running
  assert_no_expire_in_pulse_R4: assert property (@(posedge clk) disable iff (!por_n)
    wd_pulse |-> !wd_expire);

endmodule

// File: tb/test_wdr_supervisor.sv
module test_wdr_supervisor;
  localparam int unsigned BASE   = 40;
  localparam int unsigned PULSE  = 16;
  localparam int unsigned SETTLE = 24;

  logic       clk = 1'b0;
  logic       por_n;
  logic [1:0] wd_sel;
  logic       wd_kick;
  logic       lv_below;
  logic       lv_en;
  logic       host_rst_n;

  always #5 clk = ~clk;

  wdr_supervisor #(.BASE_CYC(BASE), .PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE)) i_wdr_supervisor (
    .clk(clk), .por_n(por_n), .wd_sel(wd_sel), .wd_kick(wd_kick),
    .lv_below(lv_below), .lv_en(lv_en), .host_rst_n(host_rst_n)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct {
    int unsigned fall;
    int unsigned len;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned period_of(input logic [1:0] s);
    int unsigned r;
    r = (s == 2'd0) ? BASE : (s == 2'd1) ? BASE * 3 : (s == 2'd2) ? BASE * 7 : 0;
    return r;
  endfunction

  // Monitor: measures each low pulse and compares it with the scoreboard head.
  bit          mon_on = 0;
  logic        prev = 1'b1;
  int unsigned fcyc = 0;
  int          falls = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev && !host_rst_n) begin
        fcyc = cyc;
        falls++;
      end
      if (!prev && host_rst_n) begin
        if (sbq.size() == 0) begin
          check(0, "unexpected reset pulse at cycle", int'(fcyc), -1);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(fcyc == e.fall, {e.tag, " fall cycle"}, int'(fcyc), int'(e.fall));
          check((cyc - fcyc) == e.len, {e.tag, " low length"}, int'(cyc - fcyc), int'(e.len));
        end
      end
      prev = host_rst_n;
    end
  end

  task automatic push(input int unsigned f, input int unsigned l, input string t);
    exp_t e;
    e.fall = f; e.len = l; e.tag = t;
    sbq.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sel(input logic [1:0] s, output int unsigned k);
    @(negedge clk) wd_sel = s;
    @(posedge clk);
    #1 k = cyc;
  endtask

  task automatic kick_at(output int unsigned k);
    @(negedge clk) wd_kick = 1'b1;
    @(posedge clk);
    #1 k = cyc;
    @(negedge clk) wd_kick = 1'b0;
  endtask

  task automatic lv_set(input logic v, output int unsigned k);
    @(negedge clk) lv_below = v;
    @(posedge clk);
    #1 k = cyc;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (sbq.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    check(0, "watchdog timeout of bench", 0, 1);
    summary();
  end

  initial begin
    int unsigned k, k2, l, m, r;
    int n, f0;
    por_n = 1'b0; wd_sel = 2'd3; wd_kick = 1'b0; lv_below = 1'b0; lv_en = 1'b1;
    step(3);
    check(host_rst_n == 1'b0, "R1 reset low during power-on", host_rst_n, 0);

    // R1: settling hold after power-on
    @(negedge clk) por_n = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!host_rst_n && n < 1000);
    check(n == SETTLE, "R1 power-on settle edges", n, SETTLE);
    prev = host_rst_n;
    mon_on = 1;

    // R2 short period, R4 periodic repeat
    set_sel(2'd0, k);
    push(k + period_of(2'd0), PULSE, "R2 short period");
    push(k + 2 * period_of(2'd0) + PULSE, PULSE, "R4 repeat after pulse");
    drain();
    set_sel(2'd3, k);

    // R2 middle and long periods
    set_sel(2'd1, k);
    push(k + period_of(2'd1), PULSE, "R2 middle period");
    drain();
    set_sel(2'd3, k);
    set_sel(2'd2, k);
    push(k + period_of(2'd2), PULSE, "R2 long period");
    drain();
    set_sel(2'd3, k);

    // R5: regular restarts keep reset released
    f0 = falls;
    set_sel(2'd0, k);
    for (int i = 0; i < 10; i++) begin
      step(BASE - 5);
      kick_at(k);
    end
    set_sel(2'd3, k);
    step(2);
    check(falls == f0, "R5 restarts prevent reset", falls - f0, 0);

    // R6: off setting never times out
    f0 = falls;
    step(3 * 7 * BASE);
    check(falls == f0 && host_rst_n == 1'b1, "R6 off produces no reset", falls - f0, 0);

    // R7: select change restarts from zero under the new period
    set_sel(2'd2, k);
    step(100);
    set_sel(2'd0, k2);
    push(k2 + period_of(2'd0), PULSE, "R7 select change restart");
    drain();
    set_sel(2'd3, k);

    // R3: restart strobe during the pulse is ignored
    set_sel(2'd0, k);
    push(k + BASE, PULSE, "R3 pulse with kick inside");
    push(k + 2 * BASE + PULSE, PULSE, "R3 next pulse after kicked pulse");
    step(BASE + 3);
    kick_at(k2);
    drain();
    set_sel(2'd3, k);

    // R8: low-voltage reset with settling
    lv_set(1'b1, l);
    step(10);
    lv_set(1'b0, m);
    push(l, m + SETTLE - 1 - l, "R8 low-voltage hold");
    drain();

    // R9: sensing disabled
    f0 = falls;
    lv_en = 1'b0;
    lv_set(1'b1, l);
    step(50);
    lv_set(1'b0, m);
    step(5);
    check(falls == f0 && host_rst_n == 1'b1, "R9 disabled sense ignored", falls - f0, 0);
    lv_en = 1'b1;

    // R10: low-voltage event in mid-count clears the watchdog
    set_sel(2'd0, k);
    step(20);
    lv_set(1'b1, l);
    step(5);
    lv_set(1'b0, m);
    r = m + SETTLE - 1;
    push(l, r - l, "R10 low-voltage inside count");
    push(r + BASE, PULSE, "R10 watchdog resumes from zero");
    drain();
    set_sel(2'd3, k);
    step(5);

    check(host_rst_n == 1'b1, "final reset released", host_rst_n, 1);
    summary();
  end

endmodule